// File: doc/BRIEF.md
# Character Display Address Mapper with Circular Shift

This block sits in the refresh path of a character display controller. Each request names a visible line and a column. The block returns the 7-bit display RAM address that holds the character for that position, under the current line mode. There are three modes:

- 1-line: a single window of 80 addresses.
- 2-line: two windows of 40 addresses, starting at 0x00 and at 0x40.
- 3-line: three windows of 16 addresses, starting at 0x00, 0x10 and 0x20.

A shift offset rotates the visible text inside each line's own window. Shift-left and shift-right strobes move the offset by one. A return-home strobe clears it, and so does a change of mode.

Requests and results move over valid/ready handshakes, with one register stage between them:

- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- Its address appears on the next cycle, with `out_valid` high.
- While `out_valid` is high and `out_ready` is low, the result is held unchanged and `req_ready` stays low. That back-pressure reaches the requester in the same cycle.

Mode selects and strobes are plain level and pulse inputs.

Top module: `disp_addr_mapper`

## Requirements
- R1: The mode is 3-line when `strap_three_line`=1 and `two_line`=1. It is 2-line when `two_line`=1 and `strap_three_line`=0. Every other combination selects 1-line. A new mode setting applies to requests accepted from the second rising edge after it is driven.
- R2: In 1-line mode, with shift offset `s`, the address is `((col mod 80) + s) mod 80`. So columns 0 and 79 map to 0x00 and 0x4F, and column 80 maps back to 0x00.
- R3: In 2-line mode, the line length is 40. Line index 0 is based at 0x00 and line index 1 at 0x40. The address is `base + ((col mod 40) + s) mod 40`, so line 0 ends at 0x27 and line 1 starts at 0x40.
- R4: In 3-line mode, the line length is 16. Line indices 0, 1 and 2 are based at 0x00, 0x10 and 0x20. The address is `base + ((col mod 16) + s) mod 16`.
- R5: A line index at or above the active mode's line count maps as line 0. In 1-line mode, the line index is ignored.
- R6: A clock edge with `shift_left` high and `shift_right` low raises the offset by one, wrapping from length-1 to 0. `shift_right` alone lowers it by one, wrapping from 0 to length-1. Both high together leave it unchanged.
- R7: The offset becomes 0 on any edge where `home` is high, even when shift strobes are also high. It also becomes 0 on the edge where a mode change is taken in.
- R8: After reset, `out_valid`=0, `req_ready`=1, the offset is 0 and the mode is 1-line.
- R9: `req_ready` = !`out_valid` || `out_ready`. An accepted request yields `out_valid`=1 on the next cycle. While `out_valid`=1 and `out_ready`=0, `out_addr` and `out_valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_three_line | input | 1 | Strap enabling the 3-line layout (together with two_line) |
| two_line | input | 1 | Two-line select bit |
| shift_left | input | 1 | Rotate visible text left by one position |
| shift_right | input | 1 | Rotate visible text right by one position |
| home | input | 1 | Clear the shift offset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_line | input | 2 | Visible line index |
| req_col | input | 7 | Visible column index |
| out_valid | output | 1 | Result address valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_addr | output | 7 | Display RAM address |

## Verification
The assertions check three things on every cycle:

- The handshake rules: a result is held under back-pressure, and an accepted request yields a result on the next cycle.
- The offset stays inside the active line length.
- Each strobe moves the offset by exactly one step with wrap, and return-home clears it.

The address layouts of the three modes need the bench's scenarios. So do wrapping inside each line's window after shifts, folding of out-of-range lines and columns, and clearing of the offset on a mode change. Those scenarios compare returned addresses with values worked out from the requirements.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  typedef enum logic [1:0] {
    MODE_ONE   = 2'd0,
    MODE_TWO   = 2'd1,
    MODE_THREE = 2'd2
  } disp_mode_e;
endpackage

// File: rtl/disp_mode_decode.sv
module disp_mode_decode
  import disp_addr_pkg::*;
(
  input  logic       strap_three_line,
  input  logic       two_line,
  output disp_mode_e mode
);
  always_comb begin
    if (two_line && strap_three_line) mode = MODE_THREE;
    else if (two_line)                mode = MODE_TWO;
    else                              mode = MODE_ONE;
  end
endmodule

// File: rtl/disp_shift_offset.sv
module disp_shift_offset
  import disp_addr_pkg::*;
#(
  parameter int LEN_ONE   = 80,
  parameter int LEN_TWO   = 40,
  parameter int LEN_THREE = 16,
  parameter int OFF_W     = $clog2(LEN_ONE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  disp_mode_e       mode_d,
  input  logic             shift_left,
  input  logic             shift_right,
  input  logic             home,
  output disp_mode_e       mode_q,
  output logic [OFF_W-1:0] offset,
  output logic [OFF_W-1:0] line_len
);
  localparam logic [OFF_W-1:0] L1 = OFF_W'(LEN_ONE);
  localparam logic [OFF_W-1:0] L2 = OFF_W'(LEN_TWO);
  localparam logic [OFF_W-1:0] L3 = OFF_W'(LEN_THREE);

  always_comb begin
    case (mode_q)
      MODE_TWO:   line_len = L2;
      MODE_THREE: line_len = L3;
      default:    line_len = L1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_ONE;
      offset <= '0;
    end else begin
      mode_q <= mode_d;
      if (home || (mode_d != mode_q)) begin
        offset <= '0;
      end else if (shift_left && !shift_right) begin
        offset <= (offset == line_len - 1'b1) ? '0 : offset + 1'b1;
      end else if (shift_right && !shift_left) begin
        offset <= (offset == '0) ? line_len - 1'b1 : offset - 1'b1;
      end
    end
  end
endmodule

// File: rtl/disp_addr_calc.sv
module disp_addr_calc
  import disp_addr_pkg::*;
#(
  parameter int LEN_ONE    = 80,
  parameter int LEN_TWO    = 40,
  parameter int LEN_THREE  = 16,
  parameter int SECOND_BASE = 64,
  parameter int BLOCK_STEP = 16,
  parameter int LINE_W     = 2,
  parameter int COL_W      = 7,
  parameter int ADDR_W     = 7,
  parameter int OFF_W      = $clog2(LEN_ONE)
) (
  input  disp_mode_e        mode,
  input  logic [LINE_W-1:0] line,
  input  logic [COL_W-1:0]  col,
  input  logic [OFF_W-1:0]  offset,
  input  logic [OFF_W-1:0]  line_len,
  output logic [ADDR_W-1:0] addr
);
  localparam int SUM_W = OFF_W + 1;

  logic [OFF_W-1:0]  col_fold;
  logic [SUM_W-1:0]  sum_raw;
  logic [OFF_W-1:0]  pos;
  logic [ADDR_W-1:0] base;

  always_comb begin
    case (mode)
      MODE_TWO:   col_fold = OFF_W'(col % COL_W'(LEN_TWO));
      MODE_THREE: col_fold = OFF_W'(col % COL_W'(LEN_THREE));
      default:    col_fold = OFF_W'(col % COL_W'(LEN_ONE));
    endcase
  end

  always_comb begin
    sum_raw = {1'b0, col_fold} + {1'b0, offset};
    if (sum_raw >= {1'b0, line_len}) pos = OFF_W'(sum_raw - {1'b0, line_len});
    else                             pos = OFF_W'(sum_raw);
  end

  always_comb begin
    base = '0;
    case (mode)
      MODE_TWO:   if (line == LINE_W'(1)) base = ADDR_W'(SECOND_BASE);
      MODE_THREE: if (line < LINE_W'(3))  base = ADDR_W'(int'(line) * BLOCK_STEP);
      default:    base = '0;
    endcase
  end

  assign addr = base + ADDR_W'(pos);
endmodule

// File: rtl/disp_addr_mapper.sv
module disp_addr_mapper
  import disp_addr_pkg::*;
#(
  parameter int LEN_ONE     = 80,
  parameter int LEN_TWO     = 40,
  parameter int LEN_THREE   = 16,
  parameter int SECOND_BASE = 64,
  parameter int BLOCK_STEP  = 16,
  parameter int LINE_W      = 2,
  parameter int COL_W       = 7,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_three_line,
  input  logic              two_line,
  input  logic              shift_left,
  input  logic              shift_right,
  input  logic              home,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic [COL_W-1:0]  req_col,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int OFF_W = $clog2(LEN_ONE);

  disp_mode_e        mode_d;
  disp_mode_e        mode_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  line_len;
  logic [ADDR_W-1:0] addr_next;
  logic              take;

  disp_mode_decode u_decode (
    .strap_three_line (strap_three_line),
    .two_line         (two_line),
    .mode             (mode_d)
  );

  disp_shift_offset #(
    .LEN_ONE(LEN_ONE), .LEN_TWO(LEN_TWO), .LEN_THREE(LEN_THREE), .OFF_W(OFF_W)
  ) u_offset (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_d      (mode_d),
    .shift_left  (shift_left),
    .shift_right (shift_right),
    .home        (home),
    .mode_q      (mode_q),
    .offset      (off_q),
    .line_len    (line_len)
  );

  disp_addr_calc #(
    .LEN_ONE(LEN_ONE), .LEN_TWO(LEN_TWO), .LEN_THREE(LEN_THREE),
    .SECOND_BASE(SECOND_BASE), .BLOCK_STEP(BLOCK_STEP),
    .LINE_W(LINE_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_calc (
    .mode     (mode_q),
    .line     (req_line),
    .col      (req_col),
    .offset   (off_q),
    .line_len (line_len),
    .addr     (addr_next)
  );

  assign req_ready = !out_valid || out_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_addr  <= addr_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_addr_mapper_checker.sv
module disp_addr_mapper_checker
  import disp_addr_pkg::*;
#(
  parameter int OFF_W  = 7,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_left,
  input logic              shift_right,
  input logic              home,
  input logic              req_valid,
  input logic              req_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input disp_mode_e        mode_d,
  input disp_mode_e        mode_q,
  input logic [OFF_W-1:0]  off_q,
  input logic [OFF_W-1:0]  line_len
);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);

  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < line_len);

  a_r6_left_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_left && !shift_right && !home && mode_d == mode_q) |=>
      (off_q == (($past(off_q) == $past(line_len) - 1'b1) ? '0 : $past(off_q) + 1'b1)));

  a_r6_right_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_right && !shift_left && !home && mode_d == mode_q) |=>
      (off_q == (($past(off_q) == '0) ? $past(line_len) - 1'b1 : $past(off_q) - 1'b1)));

  a_r7_home_clear: assert property (@(posedge clk) disable iff (!rst_n)
    home |=> (off_q == '0));
endmodule

bind disp_addr_mapper disp_addr_mapper_checker #(
  .OFF_W($clog2(LEN_ONE)), .ADDR_W(ADDR_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .shift_left(shift_left), .shift_right(shift_right),
  .home(home), .req_valid(req_valid), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .mode_d(mode_d), .mode_q(mode_q),
  .off_q(off_q), .line_len(line_len)
);

// File: tb/disp_addr_mapper_bench.sv
module disp_addr_mapper_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_three_line = 1'b0, two_line = 1'b0;
  logic       shift_left = 1'b0, shift_right = 1'b0, home = 1'b0;
  logic       req_valid = 1'b0, out_ready = 1'b1;
  logic       req_ready, out_valid;
  logic [1:0] req_line = '0;
  logic [6:0] req_col = '0;
  logic [6:0] out_addr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_addr_mapper u_disp_addr_mapper (
    .clk(clk), .rst_n(rst_n), .strap_three_line(strap_three_line), .two_line(two_line),
    .shift_left(shift_left), .shift_right(shift_right), .home(home),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line), .req_col(req_col),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  // vector: {strap, two_line, line[1:0], col[6:0], expected addr[6:0]}
  localparam logic [17:0] VEC [15] = '{
    {1'b0, 1'b0, 2'd0, 7'd0,  7'h00},  // R2
    {1'b0, 1'b0, 2'd0, 7'd79, 7'h4F},  // R2
    {1'b0, 1'b0, 2'd0, 7'd80, 7'h00},  // R2 column fold
    {1'b0, 1'b0, 2'd1, 7'd5,  7'h05},  // R5 line ignored
    {1'b0, 1'b1, 2'd0, 7'd39, 7'h27},  // R3
    {1'b0, 1'b1, 2'd1, 7'd0,  7'h40},  // R3
    {1'b0, 1'b1, 2'd1, 7'd39, 7'h67},  // R3
    {1'b0, 1'b1, 2'd2, 7'd3,  7'h03},  // R5
    {1'b0, 1'b1, 2'd0, 7'd80, 7'h00},  // R3 column fold
    {1'b1, 1'b1, 2'd0, 7'd15, 7'h0F},  // R4
    {1'b1, 1'b1, 2'd1, 7'd0,  7'h10},  // R4
    {1'b1, 1'b1, 2'd2, 7'd15, 7'h2F},  // R4
    {1'b1, 1'b1, 2'd3, 7'd1,  7'h01},  // R5
    {1'b1, 1'b0, 2'd0, 7'd50, 7'h32},  // R1 strap alone is 1-line
    {1'b1, 1'b1, 2'd1, 7'd17, 7'h11}   // R4 column fold
  };

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic s, input logic t);
    @(negedge clk);
    strap_three_line = s;
    two_line = t;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic l, input logic r, input logic h);
    @(negedge clk);
    shift_left = l; shift_right = r; home = h;
    @(negedge clk);
    shift_left = 1'b0; shift_right = 1'b0; home = 1'b0;
  endtask

  task automatic lookup(input logic [1:0] ln, input logic [6:0] col,
                        input logic [6:0] exp, input string req);
    @(negedge clk);
    req_line = ln; req_col = col; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({6'd0, out_valid}, 7'd1, req);
    check(out_addr, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check({6'd0, out_valid}, 7'd0, "R8 out_valid");
    check({6'd0, req_ready}, 7'd1, "R8 req_ready");
    rst_n = 1'b1;
    lookup(2'd0, 7'd9, 7'h09, "R8 offset zero, 1-line");

    for (int i = 0; i < 15; i++) begin
      set_mode(VEC[i][17], VEC[i][16]);
      lookup(VEC[i][15:14], VEC[i][13:7], VEC[i][6:0], "R1-table");
    end

    // R6 3-line shift left wraps inside each block
    set_mode(1'b1, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    lookup(2'd0, 7'd0,  7'h01, "R6 left l0c0");
    lookup(2'd0, 7'd15, 7'h00, "R6 left l0c15");
    lookup(2'd2, 7'd15, 7'h20, "R6 left l2c15");
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    lookup(2'd0, 7'd0, 7'h0F, "R6 right l0c0");
    lookup(2'd0, 7'd1, 7'h00, "R6 right l0c1");
    pulse(1'b1, 1'b1, 1'b0);
    lookup(2'd0, 7'd0, 7'h0F, "R6 both strobes no change");
    pulse(1'b0, 1'b0, 1'b1);
    lookup(2'd0, 7'd0, 7'h00, "R7 home");

    // R6 2-line shift right wraps inside 40-address lines
    set_mode(1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    lookup(2'd0, 7'd0, 7'h27, "R6 2-line l0c0");
    lookup(2'd0, 7'd1, 7'h00, "R6 2-line l0c1");
    lookup(2'd1, 7'd0, 7'h67, "R6 2-line l1c0");
    pulse(1'b1, 1'b0, 1'b1);
    lookup(2'd1, 7'd0, 7'h40, "R7 home beats shift");

    // R7 mode change clears offset
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    lookup(2'd0, 7'd0, 7'h03, "R6 three lefts");
    set_mode(1'b0, 1'b0);
    lookup(2'd0, 7'd0, 7'h00, "R7 mode change clear");
    pulse(1'b0, 1'b1, 1'b0);
    lookup(2'd0, 7'd0, 7'h4F, "R2 1-line right wrap");
    pulse(1'b0, 1'b0, 1'b1);

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    req_line = 2'd0; req_col = 7'd3; req_valid = 1'b1;
    @(negedge clk);
    check(out_addr, 7'h03, "R9 first result");
    check({6'd0, req_ready}, 7'd0, "R9 ready low under stall");
    req_col = 7'd7;
    @(negedge clk);
    check(out_addr, 7'h03, "R9 held under stall");
    check({6'd0, out_valid}, 7'd1, "R9 valid held");
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(out_addr, 7'h07, "R9 next after release");
    @(negedge clk);
    check({6'd0, out_valid}, 7'd0, "R9 drained");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule